// File: doc/BRIEF.md
# Small-Page NAND Command Sequencer

This block runs the command sequences of an 8-bit small-page NAND flash device for a simple host. The host presents one request: an operation code, a block number, a page index, a region select and a column byte. The block then drives the command-latch, address-latch, chip-enable, write-strobe and read-strobe pins and the byte-wide IO bus, and it watches the ready/busy pin. Page data goes through two byte streams with valid/ready handshakes. One stream carries bytes from the host to the device and the other carries bytes from the device to the host.

In this device family a page read is one opcode followed by three address bytes. There is no confirm opcode. The opcode chooses where the read pointer starts: the lower half of the page, the upper half, or the spare bytes. Chip enable stays low from the first command byte to the end of the request, including every busy interval. If chip enable is released part way, the device returns stale and blank data. Strobe pulse width comes from a run-time cycle count. A busy wait that never ends is cut off by a counter, and the request then finishes with a timeout flag.

Top module: `snand_seq`

## Requirements
- R1: A page read (req_op=0) sends one command byte chosen by req_region: 0x00 for region 0 (lower half), 0x01 for region 1 (upper half) and 0x50 for region 2 (spare). Exactly three address bytes follow it: the column, then the page address low byte, then its high byte. No other command byte comes before the data.
- R2: The page address is req_block*32 + req_page.
- R3: After the last read address byte the block does not pulse the read strobe until ready/busy is high. It then moves a number of bytes set by the region: 512-col for region 0, 256-col for region 1 and 16-col for region 2. Before it signals done it waits for ready again.
- R4: Chip enable falls once when a request is accepted and rises only in the cycle in which done is high. It stays low through every busy wait and data phase.
- R5: A program (req_op=1) sends the region's read-pointer opcode, then 0x80, then the three address bytes, then the data bytes taken from the write stream (count as in R3), then 0x10. It then waits for ready, sends 0x70, reads one status byte, and reports err_fail equal to bit 0 of that byte.
- R6: An erase (req_op=2) sends 0x60, then only the two page-address bytes (low, high), then 0xD0. It then waits for ready and reads status as in R5.
- R7: A read ID (req_op=3) sends 0x90 and one address byte 0x00, then delivers four bytes from the device on the read stream.
- R8: A status read (req_op=4) sends 0x70 and delivers one byte on the read stream.
- R9: Each write or read strobe stays low for exactly cfg_pulse+1 clocks. Command latch and address latch are never high together, and the two strobes are never low together. While chip enable is high all strobes are idle.
- R10: If ready/busy stays low for BUSY_LIMIT clocks of a busy wait, the request ends with done and err_timeout. No data is transferred.
- R11: While rd_valid is high and rd_ready is low, rd_valid and rd_data stay unchanged and no new bus cycle starts. Bytes arrive in device order.
- R12: done is a one-clock pulse. err_timeout and err_fail are high only together with done. req_ready is high only while the block is idle with chip enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pulse | input | CNT_W | Strobe low/high phase length minus one, in clocks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_op | input | 3 | 0 read, 1 program, 2 erase, 3 read ID, 4 status |
| req_region | input | 2 | 0 lower half, 1 upper half, 2 spare |
| req_block | input | BLK_W | Block number |
| req_page | input | PG_W | Page within block |
| req_col | input | 8 | Column within region |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program byte present |
| wr_ready | output | 1 | Program byte taken |
| rd_data | output | 8 | Byte read from device |
| rd_valid | output | 1 | Read byte present |
| rd_ready | input | 1 | Host takes read byte |
| done | output | 1 | Request finished (one clock) |
| err_timeout | output | 1 | Busy wait exceeded limit |
| err_fail | output | 1 | Status fail bit was set |
| nand_nce | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_nwe | output | 1 | Write strobe, active low |
| nand_nre | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Bus byte driven to device |
| nand_io_oe | output | 1 | Bus output enable |
| nand_io_in | input | 8 | Bus byte from device |
| nand_rb | input | 1 | Ready (1) / busy (0) |

## Verification
A wrong sequencer state appears on the bus within one byte cycle: the next latched byte has the wrong latch type or value, or there is one byte too many or too few. A byte monitor on the write strobe catches this at the end of the request. A wrong counter in the busy logic shows up as a read strobe while ready/busy is low, or as a missing or early timeout flag at done. Chip-enable and handshake errors are visible in the very cycle they happen, because chip enable may rise only together with done and a stalled read byte must not change.

// File: rtl/snand_pkg.sv
package snand_pkg;
   typedef enum logic [2:0] {
      OP_READ = 3'd0, OP_PROG = 3'd1, OP_ERASE = 3'd2, OP_ID = 3'd3, OP_STAT = 3'd4
   } op_e;

   typedef enum logic [1:0] {BK_CMD, BK_ADR, BK_WR, BK_RD} bkind_e;

   typedef enum logic [3:0] {
      ST_IDLE, ST_CMD1, ST_CMD2, ST_ADR, ST_WRD, ST_CONF,
      ST_BUSY, ST_RDD, ST_BUSY2, ST_STC, ST_STR, ST_FIN
   } st_e;

   localparam logic [7:0] C_PTR_LO = 8'h00;
   localparam logic [7:0] C_PTR_HI = 8'h01;
   localparam logic [7:0] C_PTR_SP = 8'h50;
   localparam logic [7:0] C_PSET   = 8'h80;
   localparam logic [7:0] C_PCONF  = 8'h10;
   localparam logic [7:0] C_ESET   = 8'h60;
   localparam logic [7:0] C_ECONF  = 8'hD0;
   localparam logic [7:0] C_RDID   = 8'h90;
   localparam logic [7:0] C_STAT   = 8'h70;
endpackage

// File: rtl/snand_cycle.sv
// One bus byte cycle: strobe low for cfg+1 clocks, then high for cfg+1 clocks.
module snand_cycle
   import snand_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  bkind_e           kind,
   input  logic [7:0]       wbyte,
   input  logic [CNT_W-1:0] cfg,
   input  logic [7:0]       io_in,
   output logic             act,
   output logic             fin,
   output logic             cle,
   output logic             ale,
   output logic             nwe,
   output logic             nre,
   output logic             oe,
   output logic [7:0]       io_out,
   output logic [7:0]       rbyte
);
   logic             ph;
   logic [CNT_W-1:0] cnt;
   bkind_e           kind_q;
   logic [7:0]       byte_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act    <= 1'b0;
         ph     <= 1'b0;
         cnt    <= '0;
         kind_q <= BK_CMD;
         byte_q <= '0;
         rbyte  <= '0;
      end else if (!act) begin
         if (go) begin
            act    <= 1'b1;
            ph     <= 1'b0;
            cnt    <= '0;
            kind_q <= kind;
            byte_q <= wbyte;
         end
      end else if (cnt == cfg) begin
         cnt <= '0;
         if (!ph) begin
            ph <= 1'b1;
            if (kind_q == BK_RD) rbyte <= io_in;
         end else begin
            act <= 1'b0;
         end
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign fin    = act && ph && (cnt == cfg);
   assign cle    = act && (kind_q == BK_CMD);
   assign ale    = act && (kind_q == BK_ADR);
   assign nwe    = !(act && !ph && (kind_q != BK_RD));
   assign nre    = !(act && !ph && (kind_q == BK_RD));
   assign oe     = act && (kind_q != BK_RD);
   assign io_out = byte_q;
endmodule

// File: rtl/snand_busy.sv
// Ready/busy wait: settle delay, then poll ready with a timeout limit.
module snand_busy #(
   parameter int CNT_W   = 4,
   parameter int LIMIT   = 4096,
   parameter bit RB_SYNC = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             rb,
   input  logic [CNT_W-1:0] cfg,
   output logic             act,
   output logic             fin,
   output logic             tmo
);
   localparam int TMO_W    = $clog2(LIMIT + 1);
   localparam int W        = (TMO_W > CNT_W + 2) ? TMO_W : CNT_W + 2;
   localparam int SYNC_LAT = RB_SYNC ? 2 : 0;

   logic         rb_s;
   logic         ph;
   logic [W-1:0] cnt;
   logic         at_lim;
   logic         settle_done;

   generate
      if (RB_SYNC) begin : g_sync
         logic [1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= 2'b11;
            else        sh <= {sh[0], rb};
         end
         assign rb_s = sh[1];
      end else begin : g_direct
         assign rb_s = rb;
      end
   endgenerate

   assign at_lim      = (cnt == W'(LIMIT - 1));
   assign settle_done = (cnt == W'(cfg) + W'(SYNC_LAT));
   assign fin         = act && ph && (rb_s || at_lim);
   assign tmo         = act && ph && !rb_s && at_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act <= 1'b0;
         ph  <= 1'b0;
         cnt <= '0;
      end else if (!act) begin
         if (go) begin
            act <= 1'b1;
            ph  <= 1'b0;
            cnt <= '0;
         end
      end else if (!ph) begin
         if (settle_done) begin
            ph  <= 1'b1;
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else if (fin) begin
         act <= 1'b0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/snand_seq.sv
module snand_seq
   import snand_pkg::*;
#(
   parameter int BLK_W       = 11,
   parameter int PG_W        = 5,
   parameter int PAGE_BYTES  = 512,
   parameter int SPARE_BYTES = 16,
   parameter int ID_BYTES    = 4,
   parameter int CNT_W       = 4,
   parameter int BUSY_LIMIT  = 4096,
   parameter bit RB_SYNC     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cfg_pulse,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [2:0]       req_op,
   input  logic [1:0]       req_region,
   input  logic [BLK_W-1:0] req_block,
   input  logic [PG_W-1:0]  req_page,
   input  logic [7:0]       req_col,
   input  logic [7:0]       wr_data,
   input  logic             wr_valid,
   output logic             wr_ready,
   output logic [7:0]       rd_data,
   output logic             rd_valid,
   input  logic             rd_ready,
   output logic             done,
   output logic             err_timeout,
   output logic             err_fail,
   output logic             nand_nce,
   output logic             nand_cle,
   output logic             nand_ale,
   output logic             nand_nwe,
   output logic             nand_nre,
   output logic [7:0]       nand_io_out,
   output logic             nand_io_oe,
   input  logic [7:0]       nand_io_in,
   input  logic             nand_rb
);
   localparam int PA_W  = BLK_W + PG_W;
   localparam int LEN_W = $clog2(PAGE_BYTES + 1);
   localparam int HALF  = PAGE_BYTES / 2;

   generate
      if (PA_W > 16) begin : g_bad_pa
         $error("page address exceeds two address bytes");
      end
      if (HALF > 256 || SPARE_BYTES > 256) begin : g_bad_col
         $error("region larger than one column byte can address");
      end
      if (ID_BYTES > PAGE_BYTES) begin : g_bad_id
         $error("ID length exceeds transfer counter");
      end
   endgenerate

   function automatic logic [LEN_W-1:0] span(input logic [1:0] rg, input logic [7:0] c);
      case (rg)
         2'd0:    span = LEN_W'(PAGE_BYTES) - LEN_W'(c);
         2'd1:    span = LEN_W'(HALF) - LEN_W'(c);
         default: span = LEN_W'(SPARE_BYTES) - LEN_W'(c);
      endcase
   endfunction

   st_e              st;
   op_e              op_q;
   logic [1:0]       rg_q;
   logic [7:0]       col_q;
   logic [15:0]      pa_q;
   logic [1:0]       acnt, alast;
   logic [LEN_W-1:0] n_q, bcnt;
   logic             tmo_q, fail_q;

   logic             c_go, c_act, c_fin;
   bkind_e           c_kind;
   logic [7:0]       c_byte, c_rbyte;
   logic             b_go, b_act, b_fin, b_tmo;
   logic [7:0]       cmd1_byte, adr_byte;

   snand_cycle #(.CNT_W(CNT_W)) u_cyc (
      .clk(clk), .rst_n(rst_n), .go(c_go), .kind(c_kind), .wbyte(c_byte),
      .cfg(cfg_pulse), .io_in(nand_io_in), .act(c_act), .fin(c_fin),
      .cle(nand_cle), .ale(nand_ale), .nwe(nand_nwe), .nre(nand_nre),
      .oe(nand_io_oe), .io_out(nand_io_out), .rbyte(c_rbyte)
   );

   snand_busy #(.CNT_W(CNT_W), .LIMIT(BUSY_LIMIT), .RB_SYNC(RB_SYNC)) u_busy (
      .clk(clk), .rst_n(rst_n), .go(b_go), .rb(nand_rb), .cfg(cfg_pulse),
      .act(b_act), .fin(b_fin), .tmo(b_tmo)
   );

   always_comb begin
      case (op_q)
         OP_READ, OP_PROG: cmd1_byte = (rg_q == 2'd0) ? C_PTR_LO :
                                       (rg_q == 2'd1) ? C_PTR_HI : C_PTR_SP;
         OP_ERASE:         cmd1_byte = C_ESET;
         OP_ID:            cmd1_byte = C_RDID;
         default:          cmd1_byte = C_STAT;
      endcase
      if (op_q == OP_ID)     adr_byte = 8'h00;
      else if (acnt == 2'd0) adr_byte = col_q;
      else if (acnt == 2'd1) adr_byte = pa_q[7:0];
      else                   adr_byte = pa_q[15:8];
   end

   always_comb begin
      c_go     = 1'b0;
      c_kind   = BK_CMD;
      c_byte   = 8'h00;
      wr_ready = 1'b0;
      case (st)
         ST_CMD1: begin c_go = !c_act; c_byte = cmd1_byte; end
         ST_CMD2: begin c_go = !c_act; c_byte = C_PSET; end
         ST_ADR:  begin c_go = !c_act; c_kind = BK_ADR; c_byte = adr_byte; end
         ST_WRD:  begin
            wr_ready = !c_act;
            c_go     = !c_act && wr_valid;
            c_kind   = BK_WR;
            c_byte   = wr_data;
         end
         ST_CONF: begin c_go = !c_act; c_byte = (op_q == OP_PROG) ? C_PCONF : C_ECONF; end
         ST_RDD:  begin c_go = !c_act && !rd_valid; c_kind = BK_RD; end
         ST_STC:  begin c_go = !c_act; c_byte = C_STAT; end
         ST_STR:  begin c_go = !c_act; c_kind = BK_RD; end
         default: ;
      endcase
   end

   assign b_go      = ((st == ST_BUSY) || (st == ST_BUSY2)) && !b_act;
   assign req_ready = (st == ST_IDLE);
   assign rd_data   = c_rbyte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; op_q <= OP_READ; rg_q <= '0; col_q <= '0; pa_q <= '0;
         acnt <= '0; alast <= '0; n_q <= '0; bcnt <= '0; tmo_q <= 1'b0; fail_q <= 1'b0;
         rd_valid <= 1'b0; done <= 1'b0; err_timeout <= 1'b0; err_fail <= 1'b0;
         nand_nce <= 1'b1;
      end else begin
         done        <= 1'b0;
         err_timeout <= 1'b0;
         err_fail    <= 1'b0;
         case (st)
            ST_IDLE: if (req_valid) begin
               op_q     <= op_e'(req_op);
               rg_q     <= req_region;
               col_q    <= req_col;
               pa_q     <= 16'({req_block, req_page});
               bcnt     <= '0;
               tmo_q    <= 1'b0;
               fail_q   <= 1'b0;
               nand_nce <= 1'b0;
               st       <= ST_CMD1;
               case (op_e'(req_op))
                  OP_READ, OP_PROG: n_q <= span(req_region, req_col);
                  OP_ID:            n_q <= LEN_W'(ID_BYTES);
                  default:          n_q <= LEN_W'(1);
               endcase
            end
            ST_CMD1: if (c_fin) begin
               case (op_q)
                  OP_PROG:  st <= ST_CMD2;
                  OP_READ:  begin st <= ST_ADR; acnt <= 2'd0; alast <= 2'd2; end
                  OP_ERASE: begin st <= ST_ADR; acnt <= 2'd1; alast <= 2'd2; end
                  OP_ID:    begin st <= ST_ADR; acnt <= 2'd0; alast <= 2'd0; end
                  default:  st <= ST_RDD;
               endcase
            end
            ST_CMD2: if (c_fin) begin
               st <= ST_ADR; acnt <= 2'd0; alast <= 2'd2;
            end
            ST_ADR: if (c_fin) begin
               if (acnt == alast) begin
                  case (op_q)
                     OP_READ:  st <= ST_BUSY;
                     OP_PROG:  st <= ST_WRD;
                     OP_ERASE: st <= ST_CONF;
                     default:  st <= ST_RDD;
                  endcase
               end else begin
                  acnt <= acnt + 1'b1;
               end
            end
            ST_WRD: if (c_fin) begin
               if (bcnt == n_q - 1'b1) st <= ST_CONF;
               else                    bcnt <= bcnt + 1'b1;
            end
            ST_CONF: if (c_fin) st <= ST_BUSY;
            ST_BUSY: if (b_fin) begin
               if (b_tmo) begin
                  tmo_q <= 1'b1;
                  st    <= ST_FIN;
               end else begin
                  st <= (op_q == OP_READ) ? ST_RDD : ST_STC;
               end
            end
            ST_RDD: begin
               if (c_fin) rd_valid <= 1'b1;
               if (rd_valid && rd_ready) begin
                  rd_valid <= 1'b0;
                  if (bcnt == n_q - 1'b1) st <= (op_q == OP_READ) ? ST_BUSY2 : ST_FIN;
                  else                    bcnt <= bcnt + 1'b1;
               end
            end
            ST_BUSY2: if (b_fin) begin
               tmo_q <= b_tmo;
               st    <= ST_FIN;
            end
            ST_STC: if (c_fin) st <= ST_STR;
            ST_STR: if (c_fin) begin
               fail_q <= c_rbyte[0];
               st     <= ST_FIN;
            end
            default: begin
               done        <= 1'b1;
               err_timeout <= tmo_q;
               err_fail    <= fail_q;
               nand_nce    <= 1'b1;
               st          <= ST_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/snand_seq_chk.sv
module snand_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_ready,
   input logic [7:0] rd_data,
   input logic       rd_valid,
   input logic       rd_ready,
   input logic       done,
   input logic       err_timeout,
   input logic       err_fail,
   input logic       nand_nce,
   input logic       nand_cle,
   input logic       nand_ale,
   input logic       nand_nwe,
   input logic       nand_nre,
   input logic       nand_rb
);
   p_latch_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale));
   p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_nwe && !nand_nre));
   p_quiet_deselected_r9: assert property (@(posedge clk) disable iff (!rst_n)
      nand_nce |-> (!nand_cle && !nand_ale && nand_nwe && nand_nre));
   p_nce_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_nce |=> (!nand_nce || done));
   p_read_after_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!nand_nre && $past(nand_nre)) |-> nand_rb);
   p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
   p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_err_with_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (err_timeout || err_fail) |-> done);
   p_ready_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> nand_nce);
endmodule

bind snand_seq snand_seq_chk u_chk (.*);

// File: tb/sim_snand_seq.sv
`timescale 1ns/1ps
module sim_snand_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] cfg_pulse = 4'd1;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic [2:0] req_op = '0;
   logic [1:0] req_region = '0;
   logic [10:0] req_block = '0;
   logic [4:0] req_page = '0;
   logic [7:0] req_col = '0;
   logic [7:0] wr_data = '0;
   logic       wr_valid = 1'b0;
   logic       wr_ready;
   logic [7:0] rd_data;
   logic       rd_valid;
   logic       rd_ready = 1'b0;
   logic       done, err_timeout, err_fail;
   logic       nand_nce, nand_cle, nand_ale, nand_nwe, nand_nre, nand_io_oe;
   logic [7:0] nand_io_out;
   logic [7:0] nand_io_in = '0;
   logic       nand_rb = 1'b1;

   snand_seq u0 (.*);

   always #2.5 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   // model and monitor state, written only by the monitor process
   logic [7:0] log_b [16];
   int   log_k [16];
   int   log_n, wd_n, wd_sum, rcv_n, rcv_bad, viol, nce_rise, nce_fall;
   int   lo_w, lo_c, rd_w, rd_c, btime, acnt_m, ridx, wr_idx, tick, clr_seen;
   logic [7:0] rcv_b [8];
   logic [7:0] last_cmd;
   logic prev_nwe = 1'b1, prev_nre = 1'b1, prev_nce = 1'b1;
   // controls, written only by the test process
   bit   hang = 1'b0, stall = 1'b0, exp_page = 1'b0;
   logic [7:0] stat_val = 8'h00;
   int   clr_tok = 0;
   bit   got_tmo, got_fail;

   function automatic logic [7:0] mbyte(input logic [7:0] cmd, input int i, input logic [7:0] sv);
      logic [7:0] idb [4];
      idb = '{8'hEC, 8'h75, 8'hA5, 8'hBD};
      if (cmd == 8'h90) return idb[i % 4];
      if (cmd == 8'h70) return sv;
      return 8'(i) ^ 8'hA5;
   endfunction

   initial begin
      log_n = 0; wd_n = 0; wd_sum = 0; rcv_n = 0; rcv_bad = 0; viol = 0;
      nce_rise = 0; nce_fall = 0; lo_w = 0; lo_c = 0; rd_w = 0; rd_c = 0; btime = 0;
      acnt_m = 0; ridx = 0; wr_idx = 0; tick = 0; clr_seen = 0; last_cmd = 8'hFF;
   end

   always @(negedge clk) begin
      tick++;
      if (clr_tok != clr_seen) begin
         clr_seen = clr_tok;
         log_n = 0; wd_n = 0; wd_sum = 0; rcv_n = 0; rcv_bad = 0; viol = 0;
         nce_rise = 0; nce_fall = 0; wr_idx = 0;
      end
      if (!nand_nwe) lo_c++;
      if (!prev_nwe && nand_nwe) begin
         lo_w = lo_c; lo_c = 0;
         if (nand_cle) begin
            last_cmd = nand_io_out; acnt_m = 0; ridx = 0;
            if (log_n < 16) begin log_b[log_n] = nand_io_out; log_k[log_n] = 1; end
            log_n++;
            if (nand_io_out == 8'h10 || nand_io_out == 8'hD0) btime = 20;
         end else if (nand_ale) begin
            acnt_m++;
            if (log_n < 16) begin log_b[log_n] = nand_io_out; log_k[log_n] = 2; end
            log_n++;
            if ((last_cmd == 8'h00 || last_cmd == 8'h01 || last_cmd == 8'h50) && acnt_m == 3)
               btime = 20;
         end else begin
            wd_n++; wd_sum += int'(nand_io_out);
         end
      end
      if (!nand_nre) rd_c++;
      if (prev_nre && !nand_nre && !nand_rb) viol++;
      if (!prev_nre && nand_nre) begin ridx++; rd_w = rd_c; rd_c = 0; end
      nand_io_in = mbyte(last_cmd, ridx, stat_val);
      if (btime > 0) btime--;
      nand_rb = !(hang || btime > 0);
      if (prev_nce && !nand_nce) nce_fall++;
      if (!prev_nce && nand_nce) nce_rise++;
      prev_nwe = nand_nwe; prev_nre = nand_nre; prev_nce = nand_nce;
      wr_valid = 1'b1;
      wr_data  = 8'(wr_idx);
      if (wr_ready) wr_idx++;
      rd_ready = !stall || (tick % 3 == 0);
      if (rd_valid && rd_ready) begin
         if (rcv_n < 8) rcv_b[rcv_n] = rd_data;
         if (exp_page && rd_data != (8'(rcv_n) ^ 8'hA5)) rcv_bad++;
         rcv_n++;
      end
   end

   task automatic chk(input string rq, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic chk_log(input string rq, input int i, input int k, input int b);
      chk(rq, $sformatf("bus entry %0d kind", i), log_k[i], k);
      chk(rq, $sformatf("bus entry %0d byte", i), int'(log_b[i]), b);
   endtask

   task automatic run_op(input int op, input int rg, input int blk, input int pg, input int col);
      clr_tok++;
      repeat (2) @(negedge clk);
      req_op = 3'(op); req_region = 2'(rg); req_block = 11'(blk);
      req_page = 5'(pg); req_col = 8'(col); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      got_tmo = 1'b0; got_fail = 1'b0;
      for (int i = 0; i < 20000; i++) begin
         if (done) begin got_tmo = err_timeout; got_fail = err_fail; break; end
         @(negedge clk);
      end
      chk("R12", "done seen", int'(done), 1);
      @(negedge clk);
      chk("R12", "done one clock", int'(done), 0);
      chk("R12", "idle after done", int'(req_ready), 1);
      chk("R4", "chip enable low once", nce_fall, 1);
      chk("R4", "chip enable released once", nce_rise, 1);
   endtask

   task automatic t_reset();
      chk("R12", "ready at reset", int'(req_ready), 1);
      chk("R9", "chip enable idle at reset", int'(nand_nce), 1);
      chk("R9", "strobes idle at reset", int'({nand_nwe, nand_nre, nand_cle, nand_ale}), 4'b1100);
      chk("R11", "no read byte at reset", int'(rd_valid), 0);
   endtask

   task automatic t_read_lower();
      exp_page = 1'b1;
      run_op(0, 0, 5, 3, 0);
      chk("R1", "lower read bus length", log_n, 4);
      chk_log("R1", 0, 1, 8'h00);
      chk_log("R1", 1, 2, 8'h00);
      chk_log("R2", 2, 2, 8'hA3);
      chk_log("R2", 3, 2, 8'h00);
      chk("R3", "lower read byte count", rcv_n, 512);
      chk("R3", "read strobe while busy", viol, 0);
      chk("R11", "read order", rcv_bad, 0);
      chk("R9", "read strobe width", rd_w, 2);
      chk("R10", "no timeout", int'(got_tmo), 0);
   endtask

   task automatic t_read_upper_stall();
      exp_page = 1'b1; stall = 1'b1;
      run_op(0, 1, 2047, 31, 16);
      stall = 1'b0;
      chk_log("R1", 0, 1, 8'h01);
      chk_log("R1", 1, 2, 8'h10);
      chk_log("R2", 2, 2, 8'hFF);
      chk_log("R2", 3, 2, 8'hFF);
      chk("R3", "upper read byte count", rcv_n, 240);
      chk("R11", "order under stall", rcv_bad, 0);
   endtask

   task automatic t_read_spare();
      exp_page = 1'b1;
      run_op(0, 2, 0, 1, 0);
      chk("R1", "spare read bus length", log_n, 4);
      chk_log("R1", 0, 1, 8'h50);
      chk_log("R2", 2, 2, 8'h01);
      chk("R3", "spare byte count", rcv_n, 16);
   endtask

   task automatic t_program();
      exp_page = 1'b0; stat_val = 8'h00;
      run_op(1, 0, 1, 0, 0);
      chk("R5", "program bus length", log_n, 7);
      chk_log("R5", 0, 1, 8'h00);
      chk_log("R5", 1, 1, 8'h80);
      chk_log("R5", 2, 2, 8'h00);
      chk_log("R5", 3, 2, 8'h20);
      chk_log("R5", 4, 2, 8'h00);
      chk_log("R5", 5, 1, 8'h10);
      chk_log("R5", 6, 1, 8'h70);
      chk("R5", "program byte count", wd_n, 512);
      chk("R5", "program byte sum", wd_sum, 65280);
      chk("R5", "program pass flag", int'(got_fail), 0);
      chk("R9", "write strobe width", lo_w, 2);
   endtask

   task automatic t_program_spare_fail();
      exp_page = 1'b0; stat_val = 8'h01;
      run_op(1, 2, 9, 2, 4);
      chk_log("R5", 0, 1, 8'h50);
      chk_log("R5", 2, 2, 8'h04);
      chk("R5", "spare program count", wd_n, 12);
      chk("R5", "program fail flag", int'(got_fail), 1);
   endtask

   task automatic t_erase();
      exp_page = 1'b0; stat_val = 8'hC1;
      run_op(2, 0, 100, 0, 0);
      chk("R6", "erase bus length", log_n, 5);
      chk_log("R6", 0, 1, 8'h60);
      chk_log("R6", 1, 2, 8'h80);
      chk_log("R6", 2, 2, 8'h0C);
      chk_log("R6", 3, 1, 8'hD0);
      chk_log("R6", 4, 1, 8'h70);
      chk("R6", "erase fail flag", int'(got_fail), 1);
      chk("R6", "erase data bytes", wd_n, 0);
   endtask

   task automatic t_read_id();
      exp_page = 1'b0;
      run_op(3, 0, 0, 0, 0);
      chk("R7", "ID bus length", log_n, 2);
      chk_log("R7", 0, 1, 8'h90);
      chk_log("R7", 1, 2, 8'h00);
      chk("R7", "ID byte count", rcv_n, 4);
      chk("R7", "ID byte 0", int'(rcv_b[0]), 8'hEC);
      chk("R7", "ID byte 1", int'(rcv_b[1]), 8'h75);
      chk("R7", "ID byte 3", int'(rcv_b[3]), 8'hBD);
   endtask

   task automatic t_status_wide();
      exp_page = 1'b0; stat_val = 8'hE0; cfg_pulse = 4'd3;
      run_op(4, 0, 0, 0, 0);
      cfg_pulse = 4'd1;
      chk("R8", "status bus length", log_n, 1);
      chk_log("R8", 0, 1, 8'h70);
      chk("R8", "status byte count", rcv_n, 1);
      chk("R8", "status byte", int'(rcv_b[0]), 8'hE0);
      chk("R9", "wide write strobe", lo_w, 4);
      chk("R9", "wide read strobe", rd_w, 4);
   endtask

   task automatic t_timeout();
      exp_page = 1'b0; hang = 1'b1;
      run_op(0, 0, 7, 7, 0);
      hang = 1'b0;
      chk("R10", "timeout flag", int'(got_tmo), 1);
      chk("R10", "no data after timeout", rcv_n, 0);
      repeat (30) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_read_lower();
      t_read_upper_stall();
      t_read_spare();
      t_program();
      t_program_spare_fail();
      t_erase();
      t_read_id();
      t_status_wide();
      t_timeout();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
      $finish;
   end
endmodule